// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Sequencer

This block is a clocked, synthesizable model of the device side of a bytewide nonvolatile memory that supports page writes. The active-low chip-select, write and output strobes arrive asynchronously. They pass through a two-stage synchronizer. The address and data buses go through a pipeline of the same depth, so all of them stay aligned. The first accepted byte opens a page session. Each further byte that hits the same page lands in a page buffer, and a per-byte mask records which bytes were loaded. A session stays open as long as each new load begins within a retriggerable timeout. When the timeout expires, the block raises `busy` for a fixed programming interval. At the end of that interval it copies only the loaded bytes into the storage array.

Reads use the same strobes. When chip select and output enable are both low, the block asserts `dataOe` and presents the stored byte at the synchronized address. At all other times the bus is released. The timeout, the programming time and the noise-filter width are given in clock cycles. By default they are derived from a clock-frequency parameter in MHz. A bench can override them with short values. The storage array covers the low 2^STORE_AW bytes of the address space. Higher address bits take part in page matching only.

Top module: `eeprom_page_seq`

## Requirements
- R1: After reset, `busy`, `pageErr` and `dataOe` are all low.
- R2: `dataOe` is high only while the synchronized chip select and output enable are both low. While it is high, `dataOut` equals the stored byte at `addr`.
- R3: A write is recognised only while chip select and write are low and output enable is high. A strobe with output enable held low stores nothing and opens no session.
- R4: The address is taken when the last of chip select and write falls. The data is taken when the first of them rises. Data that changes after the first rising strobe is not stored.
- R5: Programming starts once LOAD_CYC cycles pass after the last load began with no new load. `busy` then stays high for exactly PROG_CYC cycles, after which the loaded bytes read back.
- R6: A byte whose address bits above bit 6 differ from the page of the session's first byte is dropped and sets `pageErr`. `pageErr` clears when the next session opens.
- R7: Bytes of a page not loaded in a session keep their earlier contents after programming.
- R8: While `busy` is high, write strobes are ignored and open no later session. Reads still return stored data.
- R9: A write strobe that is active for fewer than GLITCH_CYC synchronized cycles is ignored.
- R10: A session has no total length limit. Loads spaced closer than the timeout keep `busy` low for any number of loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data from the bus |
| dataOut | output | DATA_W | Read data toward the bus |
| dataOe | output | 1 | Drive enable for `dataOut` (bus released when low) |
| busy | output | 1 | Internal programming in progress |
| pageErr | output | 1 | A load in this session targeted another page |

## Verification
Two situations are hard to reach from the ports. One is a strobe that arrives while programming is already running. The other is a session that outlives its own timeout only because loads keep arriving. The stimulus reaches the first by opening a session, polling `busy` until it rises, and then issuing a read and a write inside that window. It reaches the second by walking a table of eight loads. The gaps between loads are shorter than the timeout, but the whole sequence runs longer than it. The chip-select-controlled case needs the write strobe to fall before chip select, with the bus changed after chip select rises. It gets a dedicated sequence.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef struct packed {
    logic capAddr;   // latch synchronized address
    logic capData;   // track synchronized data while strobe active
    logic openPage;  // start a session: take page, clear mask
    logic loadByte;  // write latched byte into page buffer
    logic commit;    // copy masked buffer bytes into storage
  } ctlStrobe_t;
endpackage

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAGE_AW  = 7,
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctlStrobe_t        stb,
  output logic              wrAct,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int PAGE_BYTES  = 1 << PAGE_AW;
  localparam int PG_W        = ADDR_W - PAGE_AW;
  localparam int STORE_DEPTH = 1 << STORE_AW;
  localparam int STORE_PG_W  = STORE_AW - PAGE_AW;

  logic [2:0]        strb1, strb2;   // {ce, we, oe}
  logic [ADDR_W-1:0] addr1, addr2, addrLatch;
  logic [DATA_W-1:0] data1, data2, dataLatch;
  logic [PG_W-1:0]   pageReg;
  logic [PAGE_BYTES-1:0] loadMask, maskNext;
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [DATA_W-1:0] mem [STORE_DEPTH];
  logic [PAGE_AW-1:0] offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb1 <= 3'b111;
      strb2 <= 3'b111;
      addr1 <= '0;
      addr2 <= '0;
      data1 <= '0;
      data2 <= '0;
    end else begin
      strb1 <= {ceN, weN, oeN};
      strb2 <= strb1;
      addr1 <= addr;
      addr2 <= addr1;
      data1 <= dataIn;
      data2 <= data1;
    end
  end

  assign wrAct     = ~strb2[2] & ~strb2[1] & strb2[0];
  assign dataOe    = ~strb2[2] & ~strb2[0];
  assign offset    = addrLatch[PAGE_AW-1:0];
  assign pageMatch = (addrLatch[ADDR_W-1:PAGE_AW] == pageReg);
  assign dataOut   = mem[addr2[STORE_AW-1:0]];

  always_comb begin
    maskNext = stb.openPage ? '0 : loadMask;
    if (stb.loadByte) maskNext[offset] = 1'b1;
    if (stb.commit) maskNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      dataLatch <= '0;
      pageReg   <= '0;
      loadMask  <= '0;
    end else begin
      if (stb.capAddr) addrLatch <= addr2;
      if (stb.capData) dataLatch <= data2;
      if (stb.openPage) pageReg <= addrLatch[ADDR_W-1:PAGE_AW];
      loadMask <= maskNext;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.loadByte) pageBuf[offset] <= dataLatch;
  end

  always_ff @(posedge clk) begin
    if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (loadMask[i])
          mem[{pageReg[STORE_PG_W-1:0], PAGE_AW'(i)}] <= pageBuf[i];
      end
    end
  end

  // R5: programming never commits an empty buffer
  a_r5_commit_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (|loadMask));
  // R7: mask is empty right after a commit
  a_r7_mask_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.commit) |-> (loadMask == '0));
  // R6: a byte joining an open session always matches its page
  a_r6_load_same_page: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadByte && !stb.openPage) |-> pageMatch);
  // R2: the block never drives the bus during a write strobe
  a_r2_no_drive_in_write: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !wrAct);
endmodule

// File: rtl/eeprom_ctl.sv
module eeprom_ctl
  import eeprom_pkg::*;
#(
  parameter int LOAD_CYC   = 25000,
  parameter int PROG_CYC   = 2500000,
  parameter int GLITCH_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrAct,
  input  logic       pageMatch,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       pageErr
);
  localparam int LC_W = $clog2(GLITCH_CYC + 1);
  localparam int TM_W = $clog2(LOAD_CYC + 1);
  localparam int PC_W = $clog2(PROG_CYC + 1);
  localparam logic [LC_W-1:0] LOW_MIN   = LC_W'(GLITCH_CYC);
  localparam logic [TM_W-1:0] LOAD_LAST = TM_W'(LOAD_CYC - 1);
  localparam logic [PC_W-1:0] PROG_LAST = PC_W'(PROG_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;
  state_t state;

  logic            wrActQ, wrRise, wrEnd, goodEnd, expired;
  logic [LC_W-1:0] lowCnt;
  logic [TM_W-1:0] loadTimer;
  logic [PC_W-1:0] progCnt;

  assign wrRise  = wrAct & ~wrActQ;
  assign wrEnd   = ~wrAct & wrActQ;
  assign goodEnd = wrEnd && (lowCnt >= LOW_MIN);
  assign expired = (state == S_LOAD) && !wrAct && (loadTimer >= LOAD_LAST);
  assign busy    = (state == S_PROG);

  always_comb begin
    stb          = '0;
    stb.capAddr  = wrRise;
    stb.capData  = wrAct;
    stb.openPage = (state == S_IDLE) && goodEnd;
    stb.loadByte = goodEnd && ((state == S_IDLE) || ((state == S_LOAD) && pageMatch));
    stb.commit   = (state == S_PROG) && (progCnt == PROG_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wrActQ    <= 1'b0;
      lowCnt    <= '0;
      loadTimer <= '0;
      progCnt   <= '0;
      pageErr   <= 1'b0;
    end else begin
      wrActQ <= wrAct;
      if (wrRise) lowCnt <= LC_W'(1);
      else if (wrAct && lowCnt < LOW_MIN) lowCnt <= lowCnt + 1'b1;
      if (wrRise) loadTimer <= '0;
      else if (loadTimer < LOAD_LAST) loadTimer <= loadTimer + 1'b1;
      case (state)
        S_IDLE: if (goodEnd) begin
          state   <= S_LOAD;
          pageErr <= 1'b0;
        end
        S_LOAD: begin
          if (goodEnd && !pageMatch) pageErr <= 1'b1;
          else if (expired) begin
            state   <= S_PROG;
            progCnt <= '0;
          end
        end
        S_PROG: begin
          progCnt <= progCnt + 1'b1;
          if (stb.commit) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: programming ends only through a commit
  a_r5_end_by_commit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(stb.commit));
  // R8: no buffer activity while programming
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!stb.loadByte && !stb.openPage));
  // R6: the page error holds for the rest of the session
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pageErr && state == S_LOAD) |=> pageErr);
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
  import eeprom_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_AW    = 7,
  parameter int STORE_AW   = 10,
  parameter int CLK_MHZ    = 250,
  parameter int LOAD_US    = 100,
  parameter int PROG_US    = 10000,
  parameter int LOAD_CYC   = CLK_MHZ * LOAD_US,
  parameter int PROG_CYC   = CLK_MHZ * PROG_US,
  parameter int GLITCH_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              pageErr
);
  ctlStrobe_t stb;
  logic       wrAct, pageMatch;

  eeprom_ctl #(
    .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .GLITCH_CYC(GLITCH_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrAct(wrAct), .pageMatch(pageMatch),
    .stb(stb), .busy(busy), .pageErr(pageErr)
  );

  eeprom_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .STORE_AW(STORE_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .stb(stb), .wrAct(wrAct),
    .pageMatch(pageMatch), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/sim_eeprom_page_seq.sv
module sim_eeprom_page_seq;
  localparam int LOAD_CYC = 40;
  localparam int PROG_CYC = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe, busy, pageErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eeprom_page_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .GLITCH_CYC(3)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .busy(busy), .pageErr(pageErr)
  );

  // {address, data}
  localparam logic [23:0] WR_TAB [8] = '{
    {16'h0100, 8'h11}, {16'h0101, 8'h22}, {16'h0102, 8'h33}, {16'h0103, 8'h44},
    {16'h0104, 8'h55}, {16'h0105, 8'h66}, {16'h0106, 8'h77}, {16'h0107, 8'h88}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrByte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dataIn = d; oeN = 1'b1;
    @(negedge clk); ceN = 1'b0; weN = 1'b0;
    repeat (6) @(negedge clk);
    weN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rdByte(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    repeat (4) @(negedge clk);
    d = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic oe;
    rdByte(a, d, oe);
    check(oe === 1'b1 && d === exp, tag, {oe, d}, {1'b1, exp});
  endtask

  // wait for busy to rise, then measure its width in cycles
  task automatic waitProg(output int width);
    int guard = 0;
    width = 0;
    while (busy !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    while (busy === 1'b1 && width < 300) begin width++; @(negedge clk); end
  endtask

  bit tabPhase = 1'b0;
  bit busySeen = 1'b0;
  always @(negedge clk) if (tabPhase && busy === 1'b1) busySeen <= 1'b1;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int w;
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && pageErr === 1'b0 && dataOe === 1'b0, "R1 reset outputs",
          {busy, pageErr, dataOe}, 0);

    // R10: table walked as one long session
    tabPhase = 1'b1;
    for (int i = 0; i < 8; i++) wrByte(WR_TAB[i][23:8], WR_TAB[i][7:0]);
    tabPhase = 1'b0;
    check(busySeen == 1'b0, "R10 session longer than timeout stays open", busySeen, 0);
    repeat (20) @(negedge clk);
    check(busy === 1'b0, "R5 no programming before timeout", busy, 0);
    waitProg(w);
    check(w == PROG_CYC, "R5 busy width", w, PROG_CYC);
    for (int i = 0; i < 8; i++) expectRead(WR_TAB[i][23:8], WR_TAB[i][7:0], "R5/R2 table readback");
    repeat (2) @(negedge clk);
    check(dataOe === 1'b0, "R2 bus released when deselected", dataOe, 0);

    // R6 + R8: session on page 5 with a stray byte to page 2
    wrByte(16'h0280, 8'hA5);
    wrByte(16'h0101, 8'hEE);
    check(pageErr === 1'b1, "R6 page error flagged", pageErr, 1);
    while (busy !== 1'b1) @(negedge clk);
    expectRead(16'h0100, 8'h11, "R8 read during programming");
    wrByte(16'h0104, 8'h5F);
    while (busy === 1'b1) @(negedge clk);
    expectRead(16'h0280, 8'hA5, "R6 own page written");
    expectRead(16'h0101, 8'h22, "R6 stray byte dropped");
    expectRead(16'h0104, 8'h55, "R8 write during busy ignored");
    repeat (80) @(negedge clk);
    check(busy === 1'b0, "R8 no session from busy-time strobe", busy, 0);

    // R7: single byte rewrite, neighbours keep contents; R6 flag cleared
    wrByte(16'h0103, 8'h5A);
    check(pageErr === 1'b0, "R6 error cleared on new session", pageErr, 0);
    waitProg(w);
    for (int i = 0; i < 8; i++)
      expectRead(WR_TAB[i][23:8], (i == 3) ? 8'h5A : WR_TAB[i][7:0], "R7 partial page");

    // R3: output enable low blocks the write
    @(negedge clk); addr = 16'h0102; dataIn = 8'hC1; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    repeat (8) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    repeat (80) @(negedge clk);
    check(busy === 1'b0, "R3 no session with OE low", busy, 0);
    expectRead(16'h0102, 8'h33, "R3 data unchanged");

    // R9: one-cycle write glitch
    @(negedge clk); addr = 16'h0102; dataIn = 8'h99; ceN = 1'b0;
    @(negedge clk); weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    repeat (80) @(negedge clk);
    check(busy === 1'b0, "R9 glitch opens no session", busy, 0);
    expectRead(16'h0102, 8'h33, "R9 data unchanged");

    // R4: chip-select-controlled write
    @(negedge clk); addr = 16'h0301; dataIn = 8'h00; oeN = 1'b1; weN = 1'b0;
    repeat (2) @(negedge clk); addr = 16'h0305; dataIn = 8'h3C;
    @(negedge clk); ceN = 1'b0;
    repeat (6) @(negedge clk); ceN = 1'b1;
    repeat (2) @(negedge clk); dataIn = 8'hC3; addr = 16'h0306;
    repeat (2) @(negedge clk); weN = 1'b1;
    waitProg(w);
    check(w == PROG_CYC, "R4 session programmed", w, PROG_CYC);
    expectRead(16'h0305, 8'h3C, "R4 address at last fall, data at first rise");

    rdByte(16'h0100, d, oe);
    check(d === 8'h11, "R2 readback after all sessions", d, 8'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule